// File: doc/BRIEF.md
# Prioritized Fast/Normal Interrupt Entry Sequencer

This block sits beside a small 16-bit processor core and decides, each time the core retires an instruction, whether an interrupt should be entered. Nine level-sensitive request lines are sampled into a pending register. Index 0 is a single fast line and indices 1 to 8 are the normal lines 0 to 7. The lowest pending index is the candidate. It is then accepted or refused using the enable bits, the active flags, a nesting-enable bit and a priority threshold, all held inside the block.

On acceptance the block holds the core and drives a one-access-at-a-time memory port. It saves the program counter and the status word on a downward-growing stack. For a normal entry with nesting enabled it also saves a flag word. It then reads the handler address from a vector location and hands the core a new PC, a cleared status word and the final stack pointer. After reset it uses the same port to fetch the start address.

A return signal from the core clears the matching active flag. Instruction decode and the return sequence itself are left to the core.

Top module: `irq_entry_seq`

## Requirements
- R1: Request lines are sampled into a pending register once per clock. The candidate is the lowest set pending index: index 0 is the fast line and index k (1..8) is normal line k-1. If the candidate is refused, no other line is entered at that check.
- R2: A fast request is accepted only while fast-enable is set and no fast interrupt is active. It pushes PC, then the status word, and loads PC from the word read at 0xFFF6. Acceptance sets `fast_active`.
- R3: A normal line is refused when IRQ-enable is clear, or when the priority value is less than or equal to the line number.
- R4: A normal line is refused while `norm_active` is set and nesting-enable is clear.
- R5: A normal entry pushes PC, then the status word, then the flag word only when nesting-enable is set. It loads PC from the word read at 0xFFF8 plus the line number. Every entry reports `upd_sr` as zero.
- R6: The pushed flag word has fast-enable in bit 6, IRQ-enable in bit 5, nesting-enable in bit 4, the priority value held before the entry in bits 3:0, and zeros elsewhere.
- R7: When nesting-enable is set, accepting normal line L sets `prio_out` to L.
- R8: Each push writes at the current SP and then decrements SP modulo 2^16. `upd_sp` is SP after the last push.
- R9: After reset the block reads address 0xFFF7 and presents it as `upd_pc`, with `upd_sp` zero. Both enables and nesting are clear, both active flags are clear, and `prio_out` is 8.
- R10: No interrupt check is made when the completed instruction word is 0x9A98.
- R11: `core_hold` is high from the cycle after acceptance through the cycle where `upd_valid` is high. A memory access completes only in a cycle with `mem_ack` high, and a low `mem_ack` stretches the sequence.
- R12: `ret_fast` clears `fast_active` and `ret_norm` clears `norm_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_req | input | 9 | Level requests; bit 0 fast, bits 1..8 normal lines 0..7 |
| instr_done | input | 1 | Strobe: the core has retired an instruction |
| instr_word | input | 16 | Word of the retired instruction |
| ret_fast | input | 1 | Core left the fast handler |
| ret_norm | input | 1 | Core left a normal handler |
| cfg_wr | input | 1 | Load the enable and priority fields below |
| cfg_fast_en | input | 1 | Fast-enable value to load |
| cfg_irq_en | input | 1 | IRQ-enable value to load |
| cfg_nest_en | input | 1 | Nesting-enable value to load |
| cfg_prio | input | 4 | Priority threshold to load |
| cur_pc | input | 16 | Core PC to save |
| cur_sr | input | 16 | Core status word to save |
| cur_sp | input | 16 | Core stack pointer at entry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| core_hold | output | 1 | Core must stall |
| upd_valid | output | 1 | One-cycle pulse: load PC, SR, SP from below |
| upd_pc | output | 16 | New PC |
| upd_sr | output | 16 | New status word |
| upd_sp | output | 16 | New stack pointer |
| prio_out | output | 4 | Current priority threshold |
| fast_active | output | 1 | Fast handler in progress |
| norm_active | output | 1 | Normal handler in progress |

## Verification
The properties assume `mem_ack` is only meaningful while `mem_req` is high, and that `cur_pc`, `cur_sr` and `cur_sp` are valid in the cycle `instr_done` is pulsed. The bench models memory as a combinational responder whose read data is the inverted address. This makes every vector fetch distinct and predictable. The bench drives `instr_done` only while `core_hold` is low, and changes the request lines a full cycle before the strobe so that the pending register holds the intended pattern. One run alternates `mem_ack` to exercise stalls without breaking the handshake rule.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RSTV, S_PPC, S_PSR, S_PFR, S_VEC, S_DONE
  } seq_state_t;

  // Saved flag word: fields decoded by the return path of the core.
  function automatic logic [15:0] pack_flags(input logic fen, input logic ien,
                                             input logic nen, input logic [3:0] prio);
    return {9'd0, fen, ien, nen, prio};
  endfunction

endpackage

// File: rtl/irqseq_pick.sv
module irqseq_pick #(
  parameter int NLINES = 9,
  parameter int IW     = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lines_i,
  output logic [NLINES-1:0] pend_o,
  output logic              any_o,
  output logic [IW-1:0]     win_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= lines_i;
  end

  // Scan from the top so the lowest set index is left last.
  always_comb begin
    win_o = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (pend_o[i]) win_o = IW'(i);
    end
    any_o = |pend_o;
  end
endmodule

// File: rtl/irqseq_gate.sv
module irqseq_gate #(
  parameter int IW = 4,
  parameter int LW = 3,
  parameter int PW = 4
) (
  input  logic          any_i,
  input  logic [IW-1:0] win_i,
  input  logic          fast_en_i,
  input  logic          irq_en_i,
  input  logic          nest_en_i,
  input  logic [PW-1:0] prio_i,
  input  logic          fast_act_i,
  input  logic          norm_act_i,
  output logic          take_o,
  output logic          is_fast_o,
  output logic [LW-1:0] line_o
);
  logic fast_ok, norm_ok;

  always_comb begin
    is_fast_o = (win_i == '0);
    line_o    = LW'(win_i - IW'(1));
    fast_ok   = fast_en_i && !fast_act_i;
    norm_ok   = irq_en_i && (prio_i > PW'(line_o)) && !(norm_act_i && !nest_en_i);
    take_o    = any_i && (is_fast_o ? fast_ok : norm_ok);
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irqseq_pkg::*;
#(
  parameter int          AW            = 16,
  parameter int          DW            = 16,
  parameter int          NNORM         = 8,
  parameter logic [15:0] FAST_VEC      = 16'hFFF6,
  parameter logic [15:0] NORM_VEC_BASE = 16'hFFF8,
  parameter logic [15:0] RESET_VEC     = 16'hFFF7,
  parameter logic [15:0] SKIP_WORD     = 16'h9A98,
  parameter int          PRIO_RESET    = 8,
  localparam int         NLINES        = NNORM + 1,
  localparam int         IW            = $clog2(NLINES),
  localparam int         LW            = $clog2(NNORM),
  localparam int         PW            = $clog2(NNORM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_req,
  input  logic              instr_done,
  input  logic [15:0]       instr_word,
  input  logic              ret_fast,
  input  logic              ret_norm,
  input  logic              cfg_wr,
  input  logic              cfg_fast_en,
  input  logic              cfg_irq_en,
  input  logic              cfg_nest_en,
  input  logic [PW-1:0]     cfg_prio,
  input  logic [DW-1:0]     cur_pc,
  input  logic [DW-1:0]     cur_sr,
  input  logic [AW-1:0]     cur_sp,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              core_hold,
  output logic              upd_valid,
  output logic [DW-1:0]     upd_pc,
  output logic [DW-1:0]     upd_sr,
  output logic [AW-1:0]     upd_sp,
  output logic [PW-1:0]     prio_out,
  output logic              fast_active,
  output logic              norm_active
);
  seq_state_t          state;
  logic [NLINES-1:0]   pend_q;
  logic                any_pend;
  logic [IW-1:0]       win;
  logic                g_take, acc_fast, acc_go, check_ok;
  logic [LW-1:0]       acc_line;
  logic                fast_en_q, irq_en_q, nest_en_q;
  logic [PW-1:0]       prio_q;
  logic [DW-1:0]       pc_q, sr_q, fr_q;
  logic [AW-1:0]       sp_q;
  logic                kind_fast, push_fr;
  logic [LW-1:0]       line_q;
  logic [AW-1:0]       vec_addr;

  irqseq_pick #(.NLINES(NLINES), .IW(IW)) u_pick (
    .clk(clk), .rst_n(rst_n), .lines_i(line_req),
    .pend_o(pend_q), .any_o(any_pend), .win_o(win)
  );

  irqseq_gate #(.IW(IW), .LW(LW), .PW(PW)) u_gate (
    .any_i(any_pend), .win_i(win), .fast_en_i(fast_en_q), .irq_en_i(irq_en_q),
    .nest_en_i(nest_en_q), .prio_i(prio_q), .fast_act_i(fast_active),
    .norm_act_i(norm_active), .take_o(g_take), .is_fast_o(acc_fast), .line_o(acc_line)
  );

  assign check_ok = instr_done && (instr_word != SKIP_WORD) && (state == S_IDLE);
  assign acc_go   = check_ok && g_take;
  assign vec_addr = kind_fast ? AW'(FAST_VEC) : AW'(NORM_VEC_BASE) + AW'(line_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_RSTV;
      fast_en_q   <= 1'b0;
      irq_en_q    <= 1'b0;
      nest_en_q   <= 1'b0;
      prio_q      <= PW'(PRIO_RESET);
      fast_active <= 1'b0;
      norm_active <= 1'b0;
      pc_q        <= '0;
      sr_q        <= '0;
      fr_q        <= '0;
      sp_q        <= '0;
      kind_fast   <= 1'b0;
      push_fr     <= 1'b0;
      line_q      <= '0;
    end else begin
      if (ret_fast) fast_active <= 1'b0;
      if (ret_norm) norm_active <= 1'b0;
      if (cfg_wr) begin
        fast_en_q <= cfg_fast_en;
        irq_en_q  <= cfg_irq_en;
        nest_en_q <= cfg_nest_en;
        prio_q    <= cfg_prio;
      end
      unique case (state)
        S_IDLE: if (acc_go) begin
          pc_q      <= cur_pc;
          sr_q      <= cur_sr;
          sp_q      <= cur_sp;
          fr_q      <= DW'(pack_flags(fast_en_q, irq_en_q, nest_en_q, 4'(prio_q)));
          kind_fast <= acc_fast;
          line_q    <= acc_line;
          push_fr   <= !acc_fast && nest_en_q;
          if (acc_fast) fast_active <= 1'b1;
          else begin
            norm_active <= 1'b1;
            if (nest_en_q) prio_q <= PW'(acc_line);
          end
          state <= S_PPC;
        end
        S_RSTV: if (mem_ack) begin
          pc_q  <= mem_rdata;
          state <= S_DONE;
        end
        S_PPC: if (mem_ack) begin
          sp_q  <= sp_q - AW'(1);
          state <= S_PSR;
        end
        S_PSR: if (mem_ack) begin
          sp_q  <= sp_q - AW'(1);
          state <= push_fr ? S_PFR : S_VEC;
        end
        S_PFR: if (mem_ack) begin
          sp_q  <= sp_q - AW'(1);
          state <= S_VEC;
        end
        S_VEC: if (mem_ack) begin
          pc_q  <= mem_rdata;
          state <= S_DONE;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sp_q;
    mem_wdata = pc_q;
    unique case (state)
      S_RSTV: begin mem_req = 1'b1; mem_addr = AW'(RESET_VEC); end
      S_PPC:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = pc_q; end
      S_PSR:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = sr_q; end
      S_PFR:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = fr_q; end
      S_VEC:  begin mem_req = 1'b1; mem_addr = vec_addr; end
      default: ;
    endcase
  end

  assign core_hold = (state != S_IDLE);
  assign upd_valid = (state == S_DONE);
  assign upd_pc    = pc_q;
  assign upd_sr    = '0;
  assign upd_sp    = sp_q;
  assign prio_out  = prio_q;
endmodule

// File: rtl/irqseq_chk.sv
module irqseq_chk #(
  parameter int NLINES = 9,
  parameter int IW     = 4,
  parameter int LW     = 3,
  parameter int PW     = 4,
  parameter int AW     = 16,
  parameter int DW     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] pend_q,
  input logic [IW-1:0]     win,
  input logic              any_pend,
  input logic              acc_go,
  input logic              acc_fast,
  input logic [LW-1:0]     acc_line,
  input logic              nest_en_q,
  input logic [PW-1:0]     prio_out,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [AW-1:0]     mem_addr,
  input logic              upd_valid,
  input logic [DW-1:0]     upd_sr,
  input logic              core_hold,
  input logic              norm_active
);
  function automatic logic [NLINES-1:0] below(input logic [IW-1:0] k);
    logic [NLINES-1:0] m;
    m = '0;
    for (int i = 0; i < NLINES; i++) m[i] = (i < int'(k));
    return m;
  endfunction

  // R1: the chosen index is pending and nothing lower is
  a_r1_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |-> (pend_q[win] && ((pend_q & below(win)) == '0)));

  // R4: no normal entry over an active one without nesting
  a_r4_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !acc_fast) |-> (!norm_active || nest_en_q));

  // R5: status word handed back cleared
  a_r5_sr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_sr == '0));

  // R7: threshold follows the accepted line when nesting
  a_r7_prio_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !acc_fast && nest_en_q) |=> (prio_out == PW'($past(acc_line))));

  // R8: consecutive pushes step down one word
  a_r8_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (!mem_we || (mem_addr == $past(mem_addr) - AW'(1))));

  // R11: core held while results are handed over, and after acceptance
  a_r11_hold_upd: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> core_hold);
  a_r11_hold_acc: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |=> core_hold);
endmodule

bind irq_entry_seq irqseq_chk #(
  .NLINES(NLINES), .IW(IW), .LW(LW), .PW(PW), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .win(win), .any_pend(any_pend),
  .acc_go(acc_go), .acc_fast(acc_fast), .acc_line(acc_line), .nest_en_q(nest_en_q),
  .prio_out(prio_out), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .upd_valid(upd_valid), .upd_sr(upd_sr),
  .core_hold(core_hold), .norm_active(norm_active)
);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  line_req = '0;
  logic        instr_done = 1'b0;
  logic [15:0] instr_word = '0;
  logic        ret_fast = 1'b0, ret_norm = 1'b0;
  logic        cfg_wr = 1'b0, cfg_fast_en = 1'b0, cfg_irq_en = 1'b0, cfg_nest_en = 1'b0;
  logic [3:0]  cfg_prio = '0;
  logic [15:0] cur_pc = 16'h1234, cur_sr = 16'h00A5, cur_sp = 16'h0100;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        core_hold, upd_valid;
  logic [15:0] upd_pc, upd_sr, upd_sp;
  logic [3:0]  prio_out;
  logic        fast_active, norm_active;
  logic        ack_en = 1'b1, stall_mode = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [15:0] wr_addr [8];
  logic [15:0] wr_data [8];
  int wr_n = 0;
  logic        taken, hold1;
  logic [15:0] got_pc, got_sp, got_sr;

  always #2 clk = ~clk;

  assign mem_ack   = mem_req & ack_en;
  assign mem_rdata = ~mem_addr;

  always @(posedge clk) begin
    #1 ack_en = stall_mode ? ~ack_en : 1'b1;
  end

  always @(negedge clk) begin
    if (mem_req && mem_we && mem_ack && wr_n < 8) begin
      wr_addr[wr_n] = mem_addr;
      wr_data[wr_n] = mem_wdata;
      wr_n++;
    end
  end

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .line_req(line_req), .instr_done(instr_done),
    .instr_word(instr_word), .ret_fast(ret_fast), .ret_norm(ret_norm),
    .cfg_wr(cfg_wr), .cfg_fast_en(cfg_fast_en), .cfg_irq_en(cfg_irq_en),
    .cfg_nest_en(cfg_nest_en), .cfg_prio(cfg_prio), .cur_pc(cur_pc),
    .cur_sr(cur_sr), .cur_sp(cur_sp), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .core_hold(core_hold), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_sr(upd_sr), .upd_sp(upd_sp), .prio_out(prio_out),
    .fast_active(fast_active), .norm_active(norm_active)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_upd(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 30 && !seen; i++) begin
      @(negedge clk);
      if (upd_valid) begin
        seen = 1'b1; got_pc = upd_pc; got_sp = upd_sp; got_sr = upd_sr;
      end
    end
  endtask

  task automatic do_reset;
    logic s;
    rst_n = 1'b0; line_req = '0; instr_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    wait_upd(s);
    chk(s && got_pc == 16'h0008 && got_sp == 16'h0000, "R9 reset fetch", {got_pc, got_sp}, 32'h00080000);
  endtask

  task automatic cfg(input logic f, input logic i, input logic n, input logic [3:0] p);
    @(negedge clk);
    cfg_fast_en = f; cfg_irq_en = i; cfg_nest_en = n; cfg_prio = p; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic try_entry(input logic [8:0] lines, input logic [15:0] word);
    line_req = lines;
    @(negedge clk);
    wr_n = 0;
    instr_word = word; instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
    hold1 = core_hold;
    if (hold1) wait_upd(taken);
    else begin
      taken = 1'b0;
      repeat (3) @(negedge clk);
      if (core_hold) taken = 1'b1;
    end
    line_req = '0;
  endtask

  task automatic pulse_ret(input logic f);
    @(negedge clk);
    if (f) ret_fast = 1'b1; else ret_norm = 1'b1;
    @(negedge clk);
    ret_fast = 1'b0; ret_norm = 1'b0;
  endtask

  // {lines, fen, ien, nen, prio, take, npush, pc}
  localparam int NV = 10;
  localparam logic [34:0] VECS [NV] = '{
    {9'h001, 3'b100, 4'd8, 1'b1, 2'd2, 16'h0009},
    {9'h003, 3'b110, 4'd8, 1'b1, 2'd2, 16'h0009},
    {9'h003, 3'b010, 4'd8, 1'b0, 2'd0, 16'h0000},
    {9'h010, 3'b010, 4'd8, 1'b1, 2'd2, 16'h0004},
    {9'h010, 3'b000, 4'd8, 1'b0, 2'd0, 16'h0000},
    {9'h010, 3'b010, 4'd3, 1'b0, 2'd0, 16'h0000},
    {9'h010, 3'b010, 4'd4, 1'b1, 2'd2, 16'h0004},
    {9'h100, 3'b011, 4'd8, 1'b1, 2'd3, 16'h0000},
    {9'h0A0, 3'b010, 4'd8, 1'b1, 2'd2, 16'h0003},
    {9'h000, 3'b111, 4'd8, 1'b0, 2'd0, 16'h0000}
  };

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [34:0] v;
    logic [15:0] fw;
    // R9 reset state
    do_reset();
    chk(prio_out == 4'd8, "R9 prio", prio_out, 8);
    chk(!fast_active && !norm_active, "R9 active", {fast_active, norm_active}, 0);
    try_entry(9'h1FF, 16'h0000);
    chk(!taken, "R9 enables clear", taken, 0);

    // Table walk: R1 R2 R3 R5 R6
    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      do_reset();
      cfg(v[25], v[24], v[23], v[22:19]);
      try_entry(v[34:26], 16'h0000);
      chk(taken == v[18], "R1/R2/R3 accept", taken, v[18]);
      if (v[18]) begin
        chk(hold1, "R11 hold after accept", hold1, 1);
        chk(got_pc == v[15:0] && got_sr == 16'h0, "R2/R5 vector", {got_pc, got_sr}, {v[15:0], 16'h0});
        chk(wr_n == int'(v[17:16]), "R5 push count", wr_n, v[17:16]);
        chk(got_sp == 16'h0100 - 16'(v[17:16]), "R8 final sp", got_sp, 16'h0100 - 16'(v[17:16]));
        chk(wr_addr[0] == 16'h0100 && wr_data[0] == 16'h1234 && wr_addr[1] == 16'h00FF
            && wr_data[1] == 16'h00A5, "R5 push order", {wr_data[0], wr_data[1]}, 32'h123400A5);
        if (wr_n == 3) begin
          fw = {9'd0, v[25], v[24], v[23], v[22:19]};
          chk(wr_addr[2] == 16'h00FE && wr_data[2] == fw, "R6 flag word", wr_data[2], fw);
        end
      end
    end

    // R10 skip word
    do_reset();
    cfg(1'b0, 1'b1, 1'b0, 4'd8);
    try_entry(9'h002, 16'h9A98);
    chk(!taken, "R10 skip word", taken, 0);
    try_entry(9'h002, 16'h9A99);
    chk(taken && got_pc == 16'h0007, "R10 other word", got_pc, 16'h0007);

    // R4 and R12: no nesting
    chk(norm_active, "R12 norm set", norm_active, 1);
    try_entry(9'h002, 16'h0000);
    chk(!taken, "R4 refused while active", taken, 0);
    pulse_ret(1'b0);
    chk(!norm_active, "R12 ret_norm", norm_active, 0);
    try_entry(9'h002, 16'h0000);
    chk(taken, "R4 accepted after return", taken, 1);

    // R7 nesting
    do_reset();
    cfg(1'b0, 1'b1, 1'b1, 4'd8);
    try_entry(9'h040, 16'h0000);
    chk(taken && prio_out == 4'd5, "R7 prio to line5", prio_out, 5);
    chk(wr_n == 3 && wr_data[2] == 16'h0038, "R6 nest flag word", wr_data[2], 16'h0038);
    try_entry(9'h080, 16'h0000);
    chk(!taken, "R3 line6 over prio5", taken, 0);
    try_entry(9'h010, 16'h0000);
    chk(taken && prio_out == 4'd3, "R7 nested line3", prio_out, 3);
    chk(wr_data[2] == 16'h0035, "R6 old prio saved", wr_data[2], 16'h0035);

    // R2 fast already active, R12 ret_fast
    do_reset();
    cfg(1'b1, 1'b0, 1'b0, 4'd8);
    try_entry(9'h001, 16'h0000);
    chk(taken && fast_active, "R2 fast set", fast_active, 1);
    try_entry(9'h001, 16'h0000);
    chk(!taken, "R2 fast while active", taken, 0);
    pulse_ret(1'b1);
    chk(!fast_active, "R12 ret_fast", fast_active, 0);
    try_entry(9'h001, 16'h0000);
    chk(taken, "R2 fast after return", taken, 1);

    // R8 wrap
    do_reset();
    cur_sp = 16'h0000;
    cfg(1'b0, 1'b1, 1'b0, 4'd8);
    try_entry(9'h002, 16'h0000);
    chk(wr_addr[0] == 16'h0000 && wr_addr[1] == 16'hFFFF, "R8 wrap addrs", {wr_addr[0], wr_addr[1]}, 32'h0000FFFF);
    chk(got_sp == 16'hFFFE, "R8 wrap sp", got_sp, 16'hFFFE);
    cur_sp = 16'h0100;

    // R11 stalled handshake
    do_reset();
    stall_mode = 1'b1;
    cfg(1'b1, 1'b0, 1'b0, 4'd8);
    try_entry(9'h001, 16'h0000);
    chk(taken && got_pc == 16'h0009 && wr_n == 2, "R11 stalled entry", {got_pc, 16'(wr_n)}, 32'h00090002);
    chk(wr_data[0] == 16'h1234 && wr_data[1] == 16'h00A5, "R11 stalled data", {wr_data[0], wr_data[1]}, 32'h123400A5);
    stall_mode = 1'b0;

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule